// File: doc/BRIEF.md
# Per-Pixel Trigger Delay Auto-Alignment

This block sits in front of a camera's coincidence logic and lines up the trigger signals of 49 pixels in time. Every pixel passes through its own delay line, whose length is an integer number of clock taps. A common light flash that reaches all pixels at once drives a calibration run. The block measures, for every pixel, how many clock edges after a flash reference strobe its signal first appears. It averages that arrival over a power-of-two number of flashes. It then gives each pixel the delay that makes it coincide with the slowest pixel.

The readout controller holds an enable high and pulses a start strobe, then fires the light source once per flash and marks each firing with the reference strobe. While a run is in progress the block reports busy and holds its pixel outputs low. When the new delays take effect it pulses done for one cycle. Pixels that never respond in a run are reported in a 49-bit mask and keep the delays they had before. Sub-clock fine delay elements are not modelled here. Every delay is a whole number of clock cycles.

Top module: `pix_align_cal`

## Requirements
- R1: While reset is held and right after it, cal_busy and cal_done are low, pix_out and miss_mask are all zero, and every delay field of dly_taps is 0.
- R2: While the block is idle, pix_out[i] equals the value that pix_raw[i] had at the rising edge d clock edges before the most recent one, where d is the delay of pixel i held in dly_taps bits [4i+3:4i]. A delay of 0 therefore gives a one-cycle registered passthrough.
- R3: A run starts only when cal_start and cal_en are both high at a rising edge while the block is idle. cal_start while cal_en is low is ignored and cal_busy stays low.
- R4: For each flash, the measurement window covers the 16 rising edges after the edge at which flash_ref is sampled high in the waiting state. A pixel's arrival is t when the first of those edges where it is high is the (t+1)-th, so t runs from 0 to 15. The block adds the arrivals over the flashes and divides by the flash count, rounding down.
- R5: The flash count is 2^k with k = cfg_avg_log2, and any value above 4 is treated as 4. The value is captured when a run starts, and later changes to the input have no effect on that run.
- R6: On completion, the pixel whose responding average is largest gets delay 0, and every other responding pixel gets that largest average minus its own. The delays change at no other time.
- R7: A pixel that is not high at any edge of the window in at least one flash of a run has its miss_mask bit set and keeps its previous delay. The mask clears when a run starts and holds its value until the next start.
- R8: cal_busy is high from the edge that accepts a start until the run ends. While it is high, pix_out is all zero.
- R9: cal_done is high for exactly one cycle, in the cycle after the last flash is processed. In that cycle cal_busy is low and dly_taps already shows the new delays.
- R10: When cal_en is low at a rising edge during a run, the block goes idle at that edge, keeps all delays, and gives no done pulse.
- R11: After a one-flash run, pixels that rise in the same spacing as during the flash produce outputs that all rise in the same cycle, which is the latest arrival plus one cycle after the first rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Trigger clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_en | input | 1 | Enable from the readout controller; going low aborts a run |
| cal_start | input | 1 | Start strobe for a calibration run |
| flash_ref | input | 1 | Marks the firing of the common light flash |
| cfg_avg_log2 | input | 3 | Base-2 logarithm of the flash count per run |
| pix_raw | input | 49 | Raw pixel trigger signals |
| pix_out | output | 49 | Delayed pixel trigger signals, low while busy |
| cal_busy | output | 1 | Calibration run in progress |
| cal_done | output | 1 | One-cycle pulse when new delays apply |
| miss_mask | output | 49 | Pixels that did not respond in the last run |
| dly_taps | output | 196 | Per-pixel delay in clock taps, 4 bits per pixel |

## Verification
The assertions check on every cycle that the outputs stay low while busy, that done is a single-cycle pulse that follows busy, that dropping the enable ends a run, that the delays and the miss mask change only at their permitted moments, and that a completed run with any responding pixel leaves at least one delay of zero. Only the bench's scenarios can show that the measured arrivals, the rounded-down averages, the clamped flash count and the resulting delay values are correct. The same holds for keeping the delays of pixels that did not respond, and for a replayed flash coming out aligned across all 49 outputs.

// File: rtl/pac_pkg.sv
`timescale 1ns/1ps
package pac_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ARM   = 3'd1,
    ST_MEAS  = 3'd2,
    ST_NEXT  = 3'd3,
    ST_APPLY = 3'd4
  } cal_state_e;
endpackage

// File: rtl/pac_ctrl.sv
`timescale 1ns/1ps
// Sequencer for a calibration run: waits for each flash, walks the window,
// counts flashes and triggers the delay update.
module pac_ctrl
  import pac_pkg::*;
#(
  parameter int TAP_W   = 4,
  parameter int LOG_MAX = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cal_en,
  input  logic             cal_start,
  input  logic             flash_ref,
  input  logic [2:0]       avg_log2,
  output logic             busy,
  output logic             clr_all,
  output logic             clr_hit,
  output logic             meas_en,
  output logic             close_flash,
  output logic             apply,
  output logic             done,
  output logic [TAP_W-1:0] tap_idx,
  output logic [2:0]       shift_sel
);
  localparam int               CNT_W    = LOG_MAX + 1;
  localparam logic [TAP_W-1:0] TAP_LAST = TAP_W'((1 << TAP_W) - 1);
  localparam logic [2:0]       K_MAX    = 3'(LOG_MAX);

  cal_state_e       state_q, state_d;
  logic [TAP_W-1:0] tap_q, tap_d;
  logic [CNT_W-1:0] fl_q, fl_d, n_last;
  logic [2:0]       k_q, k_d, k_clamp;
  logic             done_q, done_d;
  logic             tap_en, fl_en, k_en;

  assign k_clamp = (avg_log2 > K_MAX) ? K_MAX : avg_log2;
  assign n_last  = (CNT_W'(1) << k_q) - CNT_W'(1);

  always_comb begin
    state_d     = state_q;
    tap_d       = tap_q;
    fl_d        = fl_q;
    k_d         = k_q;
    tap_en      = 1'b0;
    fl_en       = 1'b0;
    k_en        = 1'b0;
    clr_all     = 1'b0;
    clr_hit     = 1'b0;
    meas_en     = 1'b0;
    close_flash = 1'b0;
    apply       = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (cal_en && cal_start) begin
          state_d = ST_ARM;
          fl_d    = '0;
          fl_en   = 1'b1;
          k_d     = k_clamp;
          k_en    = 1'b1;
          clr_all = 1'b1;
        end
      end
      ST_ARM: begin
        if (flash_ref) begin
          state_d = ST_MEAS;
          tap_d   = '0;
          tap_en  = 1'b1;
          clr_hit = 1'b1;
        end
      end
      ST_MEAS: begin
        meas_en = 1'b1;
        if (tap_q == TAP_LAST) begin
          state_d = ST_NEXT;
        end else begin
          tap_d  = tap_q + TAP_W'(1);
          tap_en = 1'b1;
        end
      end
      ST_NEXT: begin
        close_flash = 1'b1;
        if (fl_q == n_last) begin
          state_d = ST_APPLY;
        end else begin
          fl_d    = fl_q + CNT_W'(1);
          fl_en   = 1'b1;
          state_d = ST_ARM;
        end
      end
      ST_APPLY: begin
        apply   = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
    if ((state_q != ST_IDLE) && !cal_en) begin
      state_d     = ST_IDLE;
      clr_hit     = 1'b0;
      meas_en     = 1'b0;
      close_flash = 1'b0;
      apply       = 1'b0;
    end
    done_d = apply;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tap_q   <= '0;
      fl_q    <= '0;
      k_q     <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (tap_en) tap_q <= tap_d;
      if (fl_en)  fl_q  <= fl_d;
      if (k_en)   k_q   <= k_d;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign tap_idx   = tap_q;
  assign shift_sel = k_q;
endmodule

// File: rtl/pac_meas.sv
`timescale 1ns/1ps
// Per-pixel arrival capture: first-hit detection, arrival sum, miss flag.
module pac_meas #(
  parameter int NPIX  = 49,
  parameter int TAP_W = 4,
  parameter int SUM_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr_all,
  input  logic                  clr_hit,
  input  logic                  meas_en,
  input  logic                  close_flash,
  input  logic [TAP_W-1:0]      tap_idx,
  input  logic [NPIX-1:0]       pix_raw,
  output logic [NPIX*SUM_W-1:0] sum_flat,
  output logic [NPIX-1:0]       miss
);
  for (genvar gp = 0; gp < NPIX; gp++) begin : g_px
    logic             hit_q, hit_d;
    logic             miss_q, miss_d;
    logic [SUM_W-1:0] sum_q, sum_d;
    logic             upd;

    assign upd = clr_all | clr_hit | meas_en | close_flash;

    always_comb begin
      hit_d  = hit_q;
      miss_d = miss_q;
      sum_d  = sum_q;
      if (clr_all) begin
        hit_d  = 1'b0;
        miss_d = 1'b0;
        sum_d  = '0;
      end else begin
        if (clr_hit) hit_d = 1'b0;
        if (meas_en && pix_raw[gp] && !hit_q) begin
          hit_d = 1'b1;
          sum_d = sum_q + SUM_W'(tap_idx);
        end
        if (close_flash && !hit_q) miss_d = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hit_q  <= 1'b0;
        miss_q <= 1'b0;
        sum_q  <= '0;
      end else if (upd) begin
        hit_q  <= hit_d;
        miss_q <= miss_d;
        sum_q  <= sum_d;
      end
    end

    assign sum_flat[gp*SUM_W +: SUM_W] = sum_q;
    assign miss[gp]                    = miss_q;
  end
endmodule

// File: rtl/pac_solver.sv
`timescale 1ns/1ps
// Averages the arrival sums, finds the latest responding pixel and holds
// the per-pixel delay registers.
module pac_solver #(
  parameter int NPIX  = 49,
  parameter int TAP_W = 4,
  parameter int SUM_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  apply,
  input  logic [2:0]            shift_sel,
  input  logic [NPIX*SUM_W-1:0] sum_flat,
  input  logic [NPIX-1:0]       miss,
  output logic [NPIX*TAP_W-1:0] dly_flat
);
  logic [TAP_W-1:0] avg [NPIX];
  logic [TAP_W-1:0] latest;

  always_comb begin
    for (int i = 0; i < NPIX; i++) begin
      avg[i] = TAP_W'(sum_flat[i*SUM_W +: SUM_W] >> shift_sel);
    end
  end

  always_comb begin
    latest = '0;
    for (int i = 0; i < NPIX; i++) begin
      if (!miss[i] && (avg[i] > latest)) latest = avg[i];
    end
  end

  for (genvar gp = 0; gp < NPIX; gp++) begin : g_dly
    logic [TAP_W-1:0] dly_q, dly_d;
    logic             dly_en;

    assign dly_en = apply & ~miss[gp];
    assign dly_d  = latest - avg[gp];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dly_q <= '0;
      else if (dly_en) dly_q <= dly_d;
    end

    assign dly_flat[gp*TAP_W +: TAP_W] = dly_q;
  end
endmodule

// File: rtl/pac_dline.sv
`timescale 1ns/1ps
// One pixel's tap delay line with output gating.
module pac_dline #(
  parameter int TAP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic [TAP_W-1:0] sel,
  input  logic             gate,
  output logic             dout
);
  localparam int DEPTH = 1 << TAP_W;

  logic [DEPTH-1:0] hist_q, hist_d;

  assign hist_d = {hist_q[DEPTH-2:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end

  assign dout = gate ? 1'b0 : hist_q[sel];
endmodule

// File: rtl/pix_align_cal.sv
`timescale 1ns/1ps
module pix_align_cal #(
  parameter int NPIX    = 49,
  parameter int TAP_W   = 4,
  parameter int LOG_MAX = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cal_en,
  input  logic                  cal_start,
  input  logic                  flash_ref,
  input  logic [2:0]            cfg_avg_log2,
  input  logic [NPIX-1:0]       pix_raw,
  output logic [NPIX-1:0]       pix_out,
  output logic                  cal_busy,
  output logic                  cal_done,
  output logic [NPIX-1:0]       miss_mask,
  output logic [NPIX*TAP_W-1:0] dly_taps
);
  localparam int SUM_W = TAP_W + LOG_MAX;

  logic [1:0]            rst_pipe_q;
  logic                  rst_int_n;
  logic                  clr_all, clr_hit, meas_en, close_flash, apply;
  logic [TAP_W-1:0]      tap_idx;
  logic [2:0]            shift_sel;
  logic [NPIX*SUM_W-1:0] sum_flat;

  // reset asserts at once, releases after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  pac_ctrl #(.TAP_W(TAP_W), .LOG_MAX(LOG_MAX)) ctrl_i (
    .clk(clk), .rst_n(rst_int_n), .cal_en(cal_en), .cal_start(cal_start),
    .flash_ref(flash_ref), .avg_log2(cfg_avg_log2), .busy(cal_busy),
    .clr_all(clr_all), .clr_hit(clr_hit), .meas_en(meas_en),
    .close_flash(close_flash), .apply(apply), .done(cal_done),
    .tap_idx(tap_idx), .shift_sel(shift_sel)
  );

  pac_meas #(.NPIX(NPIX), .TAP_W(TAP_W), .SUM_W(SUM_W)) meas_i (
    .clk(clk), .rst_n(rst_int_n), .clr_all(clr_all), .clr_hit(clr_hit),
    .meas_en(meas_en), .close_flash(close_flash), .tap_idx(tap_idx),
    .pix_raw(pix_raw), .sum_flat(sum_flat), .miss(miss_mask)
  );

  pac_solver #(.NPIX(NPIX), .TAP_W(TAP_W), .SUM_W(SUM_W)) solver_i (
    .clk(clk), .rst_n(rst_int_n), .apply(apply), .shift_sel(shift_sel),
    .sum_flat(sum_flat), .miss(miss_mask), .dly_flat(dly_taps)
  );

  for (genvar gp = 0; gp < NPIX; gp++) begin : g_line
    pac_dline #(.TAP_W(TAP_W)) dline_i (
      .clk(clk), .rst_n(rst_int_n), .din(pix_raw[gp]),
      .sel(dly_taps[gp*TAP_W +: TAP_W]), .gate(cal_busy), .dout(pix_out[gp])
    );
  end
endmodule

// File: rtl/pac_chk.sv
`timescale 1ns/1ps
module pac_chk #(
  parameter int NPIX  = 49,
  parameter int TAP_W = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cal_en,
  input logic                  cal_start,
  input logic                  cal_busy,
  input logic                  cal_done,
  input logic [NPIX-1:0]       pix_out,
  input logic [NPIX-1:0]       miss_mask,
  input logic [NPIX*TAP_W-1:0] dly_taps
);
  logic has_zero;

  always_comb begin
    has_zero = 1'b0;
    for (int i = 0; i < NPIX; i++) begin
      if (!miss_mask[i] && (dly_taps[i*TAP_W +: TAP_W] == '0)) has_zero = 1'b1;
    end
  end

  a_r8_out_low_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cal_busy |-> (pix_out == '0));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |=> !cal_done);

  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |-> (!cal_busy && $past(cal_busy)));

  a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_en |=> !cal_busy);

  a_r6_dly_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_done |-> $stable(dly_taps));

  a_r6_zero_ref: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_done && !(&miss_mask)) |-> has_zero);

  a_r7_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cal_busy && !cal_start) |=> $stable(miss_mask));
endmodule

bind pix_align_cal pac_chk #(.NPIX(NPIX), .TAP_W(TAP_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cal_en(cal_en), .cal_start(cal_start),
  .cal_busy(cal_busy), .cal_done(cal_done), .pix_out(pix_out),
  .miss_mask(miss_mask), .dly_taps(dly_taps)
);

// File: tb/pix_align_cal_tb_top.sv
`timescale 1ns/1ps
module pix_align_cal_tb_top;
  localparam int NPIX  = 49;
  localparam int TAP_W = 4;
  localparam int WIN   = 16;

  logic                  clk;
  logic                  rst_n;
  logic                  cal_en;
  logic                  cal_start;
  logic                  flash_ref;
  logic [2:0]            cfg_avg_log2;
  logic [NPIX-1:0]       pix_raw;
  logic [NPIX-1:0]       pix_out;
  logic                  cal_busy;
  logic                  cal_done;
  logic [NPIX-1:0]       miss_mask;
  logic [NPIX*TAP_W-1:0] dly_taps;

  int checks = 0;
  int errors = 0;
  int arr [16][NPIX];
  int model_dly [NPIX];
  bit exp_miss [NPIX];
  logic [NPIX-1:0] hist_m [WIN];

  pix_align_cal dut_i (
    .clk(clk), .rst_n(rst_n), .cal_en(cal_en), .cal_start(cal_start),
    .flash_ref(flash_ref), .cfg_avg_log2(cfg_avg_log2), .pix_raw(pix_raw),
    .pix_out(pix_out), .cal_busy(cal_busy), .cal_done(cal_done),
    .miss_mask(miss_mask), .dly_taps(dly_taps)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) begin
    for (int j = WIN - 1; j > 0; j--) hist_m[j] <= hist_m[j-1];
    hist_m[0] <= pix_raw;
  end

  function automatic int dly_of(int i);
    return int'(dly_taps[i*TAP_W +: TAP_W]);
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // expected outcome of a run of n flashes, averaging shift k
  task automatic compute_expected(int n, int k);
    int avg [NPIX];
    int latest;
    latest = -1;
    for (int i = 0; i < NPIX; i++) begin
      int sum;
      sum = 0;
      exp_miss[i] = 1'b0;
      for (int f = 0; f < n; f++) begin
        if (arr[f][i] >= WIN) exp_miss[i] = 1'b1;
        else                  sum += arr[f][i];
      end
      avg[i] = sum >> k;
      if (!exp_miss[i] && avg[i] > latest) latest = avg[i];
    end
    for (int i = 0; i < NPIX; i++) begin
      if (!exp_miss[i]) model_dly[i] = latest - avg[i];
    end
  endtask

  task automatic check_result(string req);
    for (int i = 0; i < NPIX; i++) begin
      chk(dly_of(i) == model_dly[i], req, $sformatf("delay pixel %0d", i), dly_of(i), model_dly[i]);
      chk(miss_mask[i] == exp_miss[i], "R7", $sformatf("miss pixel %0d", i), miss_mask[i], exp_miss[i]);
    end
  endtask

  task automatic traffic(int cycles);
    for (int c = 0; c < cycles; c++) begin
      logic [NPIX-1:0] expv;
      @(negedge clk);
      for (int i = 0; i < NPIX; i++) expv[i] = hist_m[model_dly[i]][i];
      chk(pix_out == expv, "R2", "delayed output mismatching bits", $countones(pix_out ^ expv), 0);
      for (int i = 0; i < NPIX; i++) pix_raw[i] = 1'($urandom_range(0, 1));
    end
    @(negedge clk);
    pix_raw = '0;
  endtask

  task automatic start_cal(int cfg);
    @(negedge clk);
    cal_en       = 1'b1;
    cal_start    = 1'b1;
    cfg_avg_log2 = 3'(cfg);
    pix_raw      = '0;
  endtask

  task automatic do_flash(int f);
    @(negedge clk);
    chk(cal_busy == 1'b1, "R8", "busy while waiting for flash", cal_busy, 1);
    cal_start = 1'b0;
    flash_ref = 1'b1;
    pix_raw   = '0;
    for (int t = 0; t < WIN; t++) begin
      @(negedge clk);
      flash_ref = 1'b0;
      if (t == 10) chk(pix_out == '0, "R8", "outputs gated while busy", $countones(pix_out), 0);
      for (int i = 0; i < NPIX; i++) pix_raw[i] = (arr[f][i] <= t);
    end
    @(negedge clk);
    pix_raw = '0;
  endtask

  task automatic wait_done(string req);
    bit seen;
    seen = 1'b0;
    for (int w = 0; w < 8 && !seen; w++) begin
      @(negedge clk);
      if (cal_done) seen = 1'b1;
    end
    chk(seen, "R9", "done pulse seen", seen, 1);
    chk(!cal_busy, "R9", "busy low with done", cal_busy, 0);
    check_result(req);
    @(negedge clk);
    chk(!cal_done, "R9", "done lasts one cycle", cal_done, 0);
  endtask

  initial begin
    #(4 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7341));
    rst_n = 1'b0; cal_en = 1'b0; cal_start = 1'b0; flash_ref = 1'b0;
    cfg_avg_log2 = 3'd4; pix_raw = '0;
    for (int i = 0; i < NPIX; i++) begin model_dly[i] = 0; exp_miss[i] = 1'b0; end

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!cal_busy && !cal_done, "R1", "busy/done in reset", {cal_busy, cal_done}, 0);
    chk(pix_out == '0 && miss_mask == '0, "R1", "outputs in reset", $countones(pix_out | miss_mask), 0);
    chk(dly_taps == '0, "R1", "delays in reset", $countones(dly_taps), 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk(!cal_busy && dly_taps == '0, "R1", "state after reset", $countones(dly_taps), 0);

    // R2: zero-delay passthrough
    traffic(20);

    // R3: start ignored without enable
    @(negedge clk);
    cal_start = 1'b1;
    @(negedge clk);
    cal_start = 1'b0;
    chk(!cal_busy, "R3", "start without enable", cal_busy, 0);
    @(negedge clk);
    chk(!cal_busy, "R3", "still idle", cal_busy, 0);
    traffic(4);

    // R4 R5 R6: sixteen jittered flashes
    for (int i = 0; i < NPIX; i++) begin
      int base;
      base = int'($urandom_range(0, 11));
      for (int f = 0; f < 16; f++) arr[f][i] = base + int'($urandom_range(0, 3));
    end
    arr[0][0] = 0; arr[0][48] = 15;
    compute_expected(16, 4);
    start_cal(4);
    for (int f = 0; f < 16; f++) do_flash(f);
    wait_done("R6");
    traffic(40);

    // R5: count above 4 clamps to 16 flashes; later input change ignored
    for (int i = 0; i < NPIX; i++)
      for (int f = 0; f < 16; f++) arr[f][i] = int'($urandom_range(0, 15));
    compute_expected(16, 4);
    start_cal(7);
    do_flash(0);
    cfg_avg_log2 = 3'd0;
    for (int f = 1; f < 16; f++) do_flash(f);
    wait_done("R5");

    // R11: single flash then aligned replay
    begin
      int lat;
      int first [NPIX];
      lat = 0;
      for (int i = 0; i < NPIX; i++) begin
        arr[0][i] = int'($urandom_range(0, 15));
        if (arr[0][i] > lat) lat = arr[0][i];
        first[i] = -1;
      end
      compute_expected(1, 0);
      start_cal(0);
      do_flash(0);
      wait_done("R4");
      pix_raw = '0;
      repeat (20) @(negedge clk);
      for (int c = 0; c < 40; c++) begin
        @(negedge clk);
        for (int i = 0; i < NPIX; i++) begin
          if (pix_out[i] && first[i] < 0) first[i] = c;
          pix_raw[i] = (c >= arr[0][i]);
        end
      end
      for (int i = 0; i < NPIX; i++)
        chk(first[i] == lat + 1, "R11", $sformatf("first rise pixel %0d", i), first[i], lat + 1);
      @(negedge clk);
      pix_raw = '0;
      repeat (20) @(negedge clk);
    end

    // R7: pixels missing in one flash keep delays; mask held afterwards
    for (int i = 0; i < NPIX; i++)
      for (int f = 0; f < 4; f++) arr[f][i] = int'($urandom_range(0, 14));
    arr[2][3] = 99;
    arr[1][40] = 99;
    compute_expected(4, 2);
    start_cal(2);
    for (int f = 0; f < 4; f++) do_flash(f);
    wait_done("R7");
    traffic(10);
    chk(miss_mask[3] && miss_mask[40] && $countones(miss_mask) == 2, "R7", "mask held",
        $countones(miss_mask), 2);

    // R7: no pixel responds at all
    for (int i = 0; i < NPIX; i++) arr[0][i] = 99;
    compute_expected(1, 0);
    start_cal(0);
    do_flash(0);
    wait_done("R7");

    // R10: abort in the middle of a run
    for (int i = 0; i < NPIX; i++)
      for (int f = 0; f < 2; f++) arr[f][i] = int'($urandom_range(0, 15));
    start_cal(4);
    do_flash(0);
    @(negedge clk);
    cal_en = 1'b0;
    @(negedge clk);
    chk(!cal_busy, "R10", "idle after abort", cal_busy, 0);
    begin
      bit any_done;
      any_done = 1'b0;
      for (int c = 0; c < 6; c++) begin
        @(negedge clk);
        if (cal_done) any_done = 1'b1;
      end
      chk(!any_done, "R10", "no done after abort", any_done, 0);
    end
    for (int i = 0; i < NPIX; i++)
      chk(dly_of(i) == model_dly[i], "R10", $sformatf("delay kept pixel %0d", i), dly_of(i), model_dly[i]);
    traffic(10);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule